// File: doc/BRIEF.md
# DDR3 Command Spacing Gate

This block sits between a DRAM command source and the command bus of one group of DDR3 banks. Each incoming command (open row, column read, column write, close row) is offered over a valid/ready handshake. The block holds the command back until every spacing rule that applies to it has run out. It then issues the command on a registered output for one cycle. It also keeps one flag per bank that says whether a row is open there, and refuses commands that contradict that flag.

Latency values come from a built-in preset table, chosen by a speed code and a low-power selector, or from override inputs. A new set of values, and the one-clock or two-clock launch spacing, takes effect only on a clock edge where no command is being offered. For each issued column command the block raises a one-cycle marker in the cycle where read data returns or where write data must be driven.

Top module: `ddr3_cmd_gate`

## Requirements
- R1: After reset every bank is closed, the spacing is one clock, the latencies are 7/7/7 with write latency 6, and `iss_valid`, `proto_err`, `rd_due` and `wr_due` are low.
- R2: With `use_ovr`=0 and `low_pwr`=0, `speed_sel` 0, 1 and 2 (3 behaves as 2) select read latency = row-to-column delay = close period = 7, 9 and 11 clocks, with write latency 6, 7 and 8.
- R3: With `use_ovr`=0 and `low_pwr`=1, `speed_sel` 0, 1 and 2 select 7/7/7, 8/8/8 and 9/9/9, with write latency 6, 6 and 7.
- R4: With `use_ovr`=1 the four override inputs set the latencies directly, and a zero override is treated as 1.
- R5: The configuration inputs are sampled only on edges where `cmd_valid` is low, so changes made while a command is offered have no effect on it.
- R6: A read or write to a bank is accepted no earlier than the edge that lies row-to-column-delay edges after that bank's open command was accepted.
- R7: An open command to a bank is accepted no earlier than the edge that lies close-period edges after that bank's close command was accepted.
- R8: With `rate_2n`=0, legal commands whose spacing rules are met are accepted on consecutive edges.
- R9: With `rate_2n`=1, two legal commands are never accepted on adjacent edges.
- R10: `rd_due` is high for one cycle exactly read-latency cycles after the cycle in which the read shows on `iss_valid`.
- R11: `wr_due` is high for one cycle exactly write-latency cycles after the cycle in which the write shows on `iss_valid`.
- R12: A read or write to a closed bank, or an open command to an open bank, is accepted at once and is not issued. `proto_err` pulses in the next cycle and no bank state changes. Op encoding: 0 open row, 1 read, 2 write, 3 close row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 2 | Preset speed code: 0 slow, 1 mid, 2 or 3 fast |
| low_pwr | input | 1 | Selects the low-power preset column |
| rate_2n | input | 1 | 1: at most one issued command every two clocks |
| use_ovr | input | 1 | 1: take latencies from the override inputs |
| ovr_cl | input | TW | Override read latency |
| ovr_rcd | input | TW | Override open-to-column delay |
| ovr_rp | input | TW | Override close period |
| ovr_cwl | input | TW | Override write latency |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command op (encoding in R12) |
| cmd_bank | input | log2(NBANK) | Target bank |
| cmd_ready | output | 1 | Command taken on this edge |
| iss_valid | output | 1 | Registered: command issued on the bus |
| iss_op | output | 2 | Op of the issued command |
| iss_bank | output | log2(NBANK) | Bank of the issued command |
| proto_err | output | 1 | Registered: last accepted command was refused |
| rd_due | output | 1 | Read data returns in this cycle |
| wr_due | output | 1 | Write data must be driven in this cycle |

## Verification
The bench measures the edge on which each command is accepted against its own model of bank timers. An off-by-one counter would move that edge by one, and a timer restarted by a refused command would stall a read that should pass at once. In two-clock mode it queues open commands to two different banks back to back; a design that ignores the gap would accept them on adjacent edges. It changes the speed and override inputs while a read is stalled; a design that latches them at that point would release the read early and report its data at the wrong latency. It also sets a zero write-latency override, which a design without the clamp would either never mark or mark in the issue cycle.

// File: rtl/ddr3_cmd_gate.sv
module ddr3_cmd_gate #(
  parameter int NBANK = 8,
  parameter int TW    = 5,
  localparam int BW   = $clog2(NBANK),
  localparam int PW   = 1 << TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    speed_sel,
  input  logic          low_pwr,
  input  logic          rate_2n,
  input  logic          use_ovr,
  input  logic [TW-1:0] ovr_cl,
  input  logic [TW-1:0] ovr_rcd,
  input  logic [TW-1:0] ovr_rp,
  input  logic [TW-1:0] ovr_cwl,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  output logic          cmd_ready,
  output logic          iss_valid,
  output logic [1:0]    iss_op,
  output logic [BW-1:0] iss_bank,
  output logic          proto_err,
  output logic          rd_due,
  output logic          wr_due
);
  localparam logic [1:0] OP_ACT = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_PRE = 2'd3;

  function automatic logic [4*TW-1:0] preset(input logic [1:0] s, input logic lp);
    int c, w;
    case (s)
      2'd0:    begin c = 7;            w = 6;            end
      2'd1:    begin c = lp ? 8 : 9;   w = lp ? 6 : 7;   end
      default: begin c = lp ? 9 : 11;  w = lp ? 7 : 8;   end
    endcase
    return {TW'(c), TW'(c), TW'(c), TW'(w)};
  endfunction

  function automatic logic [TW-1:0] atleast1(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  logic [TW-1:0]    cfg_cl, cfg_rcd, cfg_rp, cfg_cwl;
  logic             cfg_2n;
  logic [NBANK-1:0] bank_open;
  logic [TW-1:0]    rcd_cnt [NBANK];
  logic [TW-1:0]    rp_cnt  [NBANK];
  logic             gap;
  logic [PW-1:0]    rd_pipe, wr_pipe;

  wire is_col   = (cmd_op == OP_RD) || (cmd_op == OP_WR);
  wire illegal  = (is_col && !bank_open[cmd_bank]) || (cmd_op == OP_ACT && bank_open[cmd_bank]);
  wire timer_ok = (cmd_op == OP_ACT) ? (rp_cnt[cmd_bank] == '0) :
                  is_col             ? (rcd_cnt[cmd_bank] == '0) : 1'b1;
  assign cmd_ready = illegal || (!gap && timer_ok);
  wire issue    = cmd_valid && cmd_ready && !illegal;
  wire refuse   = cmd_valid && illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_cl  <= TW'(7);
      cfg_rcd <= TW'(7);
      cfg_rp  <= TW'(7);
      cfg_cwl <= TW'(6);
      cfg_2n  <= 1'b0;
    end else if (!cmd_valid) begin
      if (use_ovr)
        {cfg_cl, cfg_rcd, cfg_rp, cfg_cwl} <=
          {atleast1(ovr_cl), atleast1(ovr_rcd), atleast1(ovr_rp), atleast1(ovr_cwl)};
      else
        {cfg_cl, cfg_rcd, cfg_rp, cfg_cwl} <= preset(speed_sel, low_pwr);
      cfg_2n <= rate_2n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBANK; i++) begin
      if (!rst_n) begin
        bank_open[i] <= 1'b0;
        rcd_cnt[i]   <= '0;
        rp_cnt[i]    <= '0;
      end else begin
        if (issue && cmd_bank == BW'(i) && cmd_op == OP_ACT) begin
          bank_open[i] <= 1'b1;
          rcd_cnt[i]   <= cfg_rcd - TW'(1);
        end else if (rcd_cnt[i] != '0) begin
          rcd_cnt[i] <= rcd_cnt[i] - TW'(1);
        end
        if (issue && cmd_bank == BW'(i) && cmd_op == OP_PRE) begin
          bank_open[i] <= 1'b0;
          rp_cnt[i]    <= cfg_rp - TW'(1);
        end else if (rp_cnt[i] != '0) begin
          rp_cnt[i] <= rp_cnt[i] - TW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= 1'b0;
      iss_valid <= 1'b0;
      iss_op    <= '0;
      iss_bank  <= '0;
      proto_err <= 1'b0;
      rd_pipe   <= '0;
      wr_pipe   <= '0;
    end else begin
      gap       <= issue && cfg_2n;
      iss_valid <= issue;
      iss_op    <= cmd_op;
      iss_bank  <= cmd_bank;
      proto_err <= refuse;
      rd_pipe   <= (rd_pipe >> 1) | ((issue && cmd_op == OP_RD) ? (PW'(1) << cfg_cl)  : '0);
      wr_pipe   <= (wr_pipe >> 1) | ((issue && cmd_op == OP_WR) ? (PW'(1) << cfg_cwl) : '0);
    end
  end

  assign rd_due = rd_pipe[0];
  assign wr_due = wr_pipe[0];

  a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> $stable(cfg_cl) && $stable(cfg_rcd) && $stable(cfg_rp) && $stable(cfg_cwl) && $stable(cfg_2n));
  a_r6_col_after_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_col |-> rcd_cnt[cmd_bank] == '0 && bank_open[cmd_bank]);
  a_r7_act_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
    issue && cmd_op == OP_ACT |-> rp_cnt[cmd_bank] == '0);
  a_r9_two_clock_gap: assert property (@(posedge clk) disable iff (!rst_n)
    issue && cfg_2n |=> !issue);
  a_r12_refuse_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> bank_open == $past(bank_open));
endmodule

// File: tb/tb_ddr3_cmd_gate.sv
module tb_ddr3_cmd_gate;
  localparam int NB = 8, TW = 5;
  localparam int K_ISS = 0, K_ERR = 1, K_RD = 2, K_WR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] speed_sel = '0, cmd_op = '0;
  logic low_pwr = 0, rate_2n = 0, use_ovr = 0, cmd_valid = 0;
  logic [TW-1:0] ovr_cl = '0, ovr_rcd = '0, ovr_rp = '0, ovr_cwl = '0;
  logic [2:0] cmd_bank = '0, iss_bank;
  logic cmd_ready, iss_valid, proto_err, rd_due, wr_due;
  logic [1:0] iss_op;

  ddr3_cmd_gate #(.NBANK(NB), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .low_pwr(low_pwr), .rate_2n(rate_2n),
    .use_ovr(use_ovr), .ovr_cl(ovr_cl), .ovr_rcd(ovr_rcd), .ovr_rp(ovr_rp), .ovr_cwl(ovr_cwl),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ready(cmd_ready),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_bank(iss_bank), .proto_err(proto_err),
    .rd_due(rd_due), .wr_due(wr_due));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, miscomp = 0, cur_req = 1;
  bit mon_on = 0;

  typedef struct { int kind; int bank; int op; int when; int req; } exp_t;
  exp_t sb[$];

  int m_cl = 7, m_rcd = 7, m_rp = 7, m_cwl = 6;
  bit m_2n = 0;
  int act_t[NB], pre_t[NB];
  bit open_m[NB];
  int last_t = -100;

  task automatic check(bit ok, int req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe(int k, bit obs, string what);
    int idx = -1;
    bit ok;
    foreach (sb[i]) if (sb[i].kind == k && sb[i].when == cyc) idx = i;
    if (obs || idx >= 0) begin
      ok = obs && (idx >= 0);
      if (ok && k == K_ISS) ok = (int'(iss_op) == sb[idx].op) && (int'(iss_bank) == sb[idx].bank);
      check(ok, (idx >= 0) ? sb[idx].req : cur_req, what, int'(obs), int'(idx >= 0));
      if (idx >= 0) sb.delete(idx);
    end
  endtask

  // scoreboard monitor: issue R8/R12, read due R10, write due R11
  always @(negedge clk) if (mon_on) begin
    observe(K_ISS, iss_valid, "issue");
    observe(K_ERR, proto_err, "protocol error");
    observe(K_RD,  rd_due,    "read data due");
    observe(K_WR,  wr_due,    "write data due");
  end

  task automatic set_cfg(int sp, bit lp, bit n2, bit ov, int ocl, int orcd, int orp, int ocwl);
    @(negedge clk);
    cmd_valid = 0; speed_sel = 2'(sp); low_pwr = lp; rate_2n = n2; use_ovr = ov;
    ovr_cl = TW'(ocl); ovr_rcd = TW'(orcd); ovr_rp = TW'(orp); ovr_cwl = TW'(ocwl);
    @(negedge clk);
    m_2n = n2;
    if (ov) begin
      m_cl = (ocl == 0) ? 1 : ocl;   m_rcd = (orcd == 0) ? 1 : orcd;
      m_rp = (orp == 0) ? 1 : orp;   m_cwl = (ocwl == 0) ? 1 : ocwl;
    end else if (sp == 0) begin
      m_cl = 7; m_cwl = 6;
    end else if (sp == 1) begin
      m_cl = lp ? 8 : 9; m_cwl = lp ? 6 : 7;
    end else begin
      m_cl = lp ? 9 : 11; m_cwl = lp ? 7 : 8;
    end
    if (!ov) begin m_rcd = m_cl; m_rp = m_cl; end
  endtask

  // driver: op 0 open, 1 read, 2 write, 3 close
  task automatic send(int op, int b, int req, bit midchange = 0);
    int n0, nexp, nacc;
    bit bad;
    exp_t e;
    cur_req = req;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_bank = 3'(b);
    #1;
    n0 = cyc;
    bad = ((op == 1 || op == 2) && !open_m[b]) || (op == 0 && open_m[b]);
    nexp = n0;
    if (!bad) begin
      if (last_t + (m_2n ? 2 : 1) > nexp) nexp = last_t + (m_2n ? 2 : 1);
      if (op == 0 && pre_t[b] + m_rp > nexp) nexp = pre_t[b] + m_rp;
      if ((op == 1 || op == 2) && act_t[b] + m_rcd > nexp) nexp = act_t[b] + m_rcd;
    end
    while (!cmd_ready) begin
      if (midchange) begin  // R5: inputs move while the command waits
        speed_sel = 2'd0; low_pwr = 1; use_ovr = 1; ovr_cl = TW'(2); ovr_rcd = TW'(2); rate_2n = 1;
        midchange = 0;
      end
      @(negedge clk); #1;
      if (cyc > n0 + 64) break;
    end
    nacc = cyc;
    check(nacc == nexp, req, "accept edge offset", nacc - n0, nexp - n0);
    e.bank = b; e.op = op; e.req = req; e.when = nacc + 1;
    e.kind = bad ? K_ERR : K_ISS;
    sb.push_back(e);
    if (!bad) begin
      last_t = nacc;
      if (op == 0) begin open_m[b] = 1; act_t[b] = nacc; end
      if (op == 3) begin open_m[b] = 0; pre_t[b] = nacc; end
      if (op == 1) begin e.kind = K_RD; e.req = 10; e.when = nacc + 1 + m_cl;  sb.push_back(e); end
      if (op == 2) begin e.kind = K_WR; e.req = 11; e.when = nacc + 1 + m_cwl; sb.push_back(e); end
    end
    @(posedge clk);
  endtask

  initial begin
    foreach (act_t[i]) begin act_t[i] = -100; pre_t[i] = -100; open_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1: quiet outputs after reset
    check(!iss_valid && !proto_err && !rd_due && !wr_due, 1, "outputs after reset",
          int'({iss_valid, proto_err, rd_due, wr_due}), 0);
    mon_on = 1;
    send(1, 0, 1);              // R1/R12: read to closed bank refused
    set_cfg(2, 0, 0, 0, 0, 0, 0, 0);
    send(0, 0, 2);              // R2 fast preset
    send(1, 0, 6);              // R6: waits 11
    send(2, 0, 8);              // R8: next edge, write latency 8
    send(0, 0, 12);             // R12: open to open bank refused
    send(1, 0, 12);             // R12: no timer restart, immediate
    send(3, 0, 7);
    send(0, 0, 7);              // R7: waits 11
    set_cfg(1, 1, 1, 0, 0, 0, 0, 0);
    send(0, 1, 3);              // R3 low-power mid preset
    send(0, 2, 9);              // R9: two-clock gap
    send(1, 1, 3);              // R3: open-to-column 8
    send(1, 2, 9);
    send(2, 1, 9);
    set_cfg(1, 0, 0, 0, 0, 0, 0, 0);
    send(0, 3, 5);
    send(1, 3, 5, 1);           // R5: still 9 clocks
    send(2, 3, 5);
    set_cfg(0, 0, 0, 1, 5, 3, 4, 0);
    send(0, 4, 4);              // R4 overrides
    send(1, 4, 4);
    send(2, 4, 4);              // R4: zero write latency clamps to 1
    send(3, 4, 4);
    send(0, 4, 4);
    set_cfg(3, 0, 0, 0, 0, 0, 0, 0);
    send(0, 5, 2);              // R2: code 3 acts as fast
    send(1, 5, 2);
    @(negedge clk); cmd_valid = 0;
    repeat (40) @(negedge clk);
    foreach (sb[i]) check(0, sb[i].req, "event never seen", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  always @(posedge clk) if (cyc > 150000) begin
    miscomp++;
    $display("FAIL all requirements: watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule